// File: doc/BRIEF.md
# Pairwise Edge Trigger Lookup Unit

This block watches a 32-channel sample stream for programmable transitions. It keeps the last accepted sample and splits the channels into 16 adjacent pairs. Each pair has a 16-entry truth table. The table is addressed by the previous and current values of the pair's two channels. A table can encode a rising edge, a falling edge, any edge, or "no change" on either channel of its pair.

Two independent units share the same sample stream. Each unit raises its hit bit when any of its 16 pairs matches. Software-side logic loads a unit's tables in two steps: it first writes a select code, then writes a burst of 32-bit words. A summing stage downstream combines the hit bits with other trigger terms.

Top module: `edge_lut_trig`

## Requirements
- R1: After reset all tables are zero, so `hit_o` stays 0 for any sample stream until a table word is written.
- R2: Pair p covers channel 2p+1 (high) and channel 2p (low). Its table bit is addressed by the 4-bit index {prev_high, prev_low, cur_high, cur_low}, with cur_low as bit 0. With this index, the truth tables are:
  - low-channel rising: 16'h0A0A
  - high-channel rising: 16'h00CC
  - low-channel falling: 16'h5050
  - high-channel falling: 16'h3300
  - any edge: the OR of the rising and falling tables
  - constant channel: the 16-bit complement of the any-edge table
- R3: A select write with code 8'h34 targets unit 0 and code 8'h35 targets unit 1. Any other code targets no unit, and the following table writes change nothing. A table write in the same cycle as a select write is dropped.
- R4: After a select, write k (k = 0..7) loads bits [31:16] into pair 15-2k and bits [15:0] into pair 14-2k. Further writes are ignored until the next select. Pairs that were not written keep their contents.
- R5: A unit's hit is the OR of its 16 pair lookups.
- R6: `hit_o` is registered. It is valid in the cycle after a valid sample, and it is 0 in the cycle after any cycle without a valid sample.
- R7: The previous-sample register updates only on valid samples. Data presented while `sample_valid_i` is low has no effect on later comparisons.
- R8: `arm_i` discards the previous sample. A sample presented in the arm cycle is dropped. The first valid sample after reset or arm gives no hit.
- R9: The two units are independent. Loading one unit leaves the other unit's hits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Discard the stored previous sample |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | 32 | Channel sample |
| cfg_sel_valid_i | input | 1 | Select-code write strobe |
| cfg_sel_i | input | 8 | Select code |
| cfg_wr_valid_i | input | 1 | Table word write strobe |
| cfg_wr_data_i | input | 32 | Table word, two pair tables |
| hit_o | output | 2 | Per-unit edge hit, registered |

## Verification
The cases that are hardest to reach from the ports are the dropped writes:
- a ninth word after a full load;
- a word that arrives in the same cycle as a select;
- words that follow an unknown select code;
- a partial reload that must leave the remaining pairs intact.

None of these shows on `hit_o` unless a later sample stream touches exactly the pairs that the dropped word would have changed. The stimulus therefore follows each such sequence with transitions on the affected channels. A bench model of the tables, built from the requirements, predicts every hit.

// File: rtl/edge_lut_pkg.sv
package edge_lut_pkg;
  localparam int unsigned PAIR_LUT_W = 16;
  localparam int unsigned PAIR_IDX_W = 4;
  typedef logic [PAIR_LUT_W-1:0] pair_lut_t;
endpackage

// File: rtl/edge_lut_cfg.sv
module edge_lut_cfg #(
  parameter int NUM_UNITS   = 2,
  parameter int SEL_W       = 8,
  parameter int SEL_BASE    = 52,
  parameter int WR_PER_LOAD = 8,
  parameter int PTR_W       = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_valid_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 wr_valid_i,
  output logic [NUM_UNITS-1:0] unit_we_o,
  output logic [PTR_W-1:0]     wr_ptr_o
);
  logic [NUM_UNITS-1:0] act_q, act_d;
  logic [PTR_W-1:0]     ptr_q;
  logic                 wr_ok;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_dec
    assign act_d[u] = (sel_i == SEL_W'(SEL_BASE + u));
  end

  // select wins over a write in the same cycle
  assign wr_ok = wr_valid_i && !sel_valid_i && (|act_q) &&
                 (ptr_q < PTR_W'(WR_PER_LOAD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      ptr_q <= '0;
    end else if (sel_valid_i) begin
      act_q <= act_d;
      ptr_q <= '0;
    end else if (wr_ok) begin
      ptr_q <= ptr_q + PTR_W'(1);
    end
  end

  assign unit_we_o = act_q & {NUM_UNITS{wr_ok}};
  assign wr_ptr_o  = ptr_q;
endmodule

// File: rtl/edge_lut_table.sv
module edge_lut_table
  import edge_lut_pkg::*;
#(
  parameter int NUM_PAIRS = 16,
  parameter int WORD_W    = 32,
  parameter int PTR_W     = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [PTR_W-1:0]                ptr_i,
  input  logic [WORD_W-1:0]               data_i,
  output logic [NUM_PAIRS*PAIR_LUT_W-1:0] tbl_o
);
  localparam int PPW = WORD_W / PAIR_LUT_W;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int K = (NUM_PAIRS - 1 - p) / PPW;  // write slot, high pairs first
    localparam int S = p % PPW;                    // field within the word
    pair_lut_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && ptr_i == PTR_W'(K)) q <= data_i[S*PAIR_LUT_W +: PAIR_LUT_W];
    end
    assign tbl_o[p*PAIR_LUT_W +: PAIR_LUT_W] = q;
  end
endmodule

// File: rtl/edge_lut_eval.sv
module edge_lut_eval
  import edge_lut_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int NUM_UNITS = 2,
  parameter int NUM_PAIRS = 16
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      arm_i,
  input  logic                                      valid_i,
  input  logic [NUM_CH-1:0]                         sample_i,
  input  logic [NUM_UNITS*NUM_PAIRS*PAIR_LUT_W-1:0] tbl_i,
  output logic [NUM_UNITS-1:0]                      hit_o
);
  logic [NUM_CH-1:0]              prev_q;
  logic                           pv_q;
  logic [NUM_UNITS-1:0]           hit_q, unit_hit;
  logic [NUM_UNITS*NUM_PAIRS-1:0] pair_hit;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic [PAIR_IDX_W-1:0] idx;
      pair_lut_t             t;
      assign idx = {prev_q[2*p+1], prev_q[2*p], sample_i[2*p+1], sample_i[2*p]};
      assign t   = tbl_i[(u*NUM_PAIRS+p)*PAIR_LUT_W +: PAIR_LUT_W];
      assign pair_hit[u*NUM_PAIRS+p] = t[idx];
    end
    assign unit_hit[u] = |pair_hit[u*NUM_PAIRS +: NUM_PAIRS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pv_q   <= 1'b0;
      hit_q  <= '0;
    end else if (arm_i) begin
      pv_q  <= 1'b0;
      hit_q <= '0;
    end else if (valid_i) begin
      prev_q <= sample_i;
      pv_q   <= 1'b1;
      hit_q  <= pv_q ? unit_hit : '0;
    end else begin
      hit_q <= '0;
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/edge_lut_trig.sv
module edge_lut_trig
  import edge_lut_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int NUM_UNITS = 2,
  parameter int SEL_W     = 8,
  parameter int SEL_BASE  = 52,
  parameter int WORD_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 arm_i,
  input  logic                 sample_valid_i,
  input  logic [NUM_CH-1:0]    sample_i,
  input  logic                 cfg_sel_valid_i,
  input  logic [SEL_W-1:0]     cfg_sel_i,
  input  logic                 cfg_wr_valid_i,
  input  logic [WORD_W-1:0]    cfg_wr_data_i,
  output logic [NUM_UNITS-1:0] hit_o
);
  localparam int NUM_PAIRS   = NUM_CH / 2;
  localparam int PPW         = WORD_W / PAIR_LUT_W;
  localparam int WR_PER_LOAD = NUM_PAIRS / PPW;
  localparam int PTR_W       = $clog2(WR_PER_LOAD + 1);
  localparam int UNIT_BITS   = NUM_PAIRS * PAIR_LUT_W;

  logic [NUM_UNITS-1:0]           unit_we;
  logic [PTR_W-1:0]               wr_ptr;
  logic [NUM_UNITS*UNIT_BITS-1:0] tbl_all;

  edge_lut_cfg #(
    .NUM_UNITS(NUM_UNITS), .SEL_W(SEL_W), .SEL_BASE(SEL_BASE),
    .WR_PER_LOAD(WR_PER_LOAD), .PTR_W(PTR_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_valid_i(cfg_sel_valid_i),
    .sel_i(cfg_sel_i), .wr_valid_i(cfg_wr_valid_i),
    .unit_we_o(unit_we), .wr_ptr_o(wr_ptr)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_tbl
    edge_lut_table #(.NUM_PAIRS(NUM_PAIRS), .WORD_W(WORD_W), .PTR_W(PTR_W)) u_tbl (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(unit_we[u]), .ptr_i(wr_ptr),
      .data_i(cfg_wr_data_i), .tbl_o(tbl_all[u*UNIT_BITS +: UNIT_BITS])
    );
  end

  edge_lut_eval #(.NUM_CH(NUM_CH), .NUM_UNITS(NUM_UNITS), .NUM_PAIRS(NUM_PAIRS)) u_eval (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .valid_i(sample_valid_i),
    .sample_i(sample_i), .tbl_i(tbl_all), .hit_o(hit_o)
  );
endmodule

// File: rtl/edge_lut_trig_chk.sv
module edge_lut_trig_chk #(
  parameter int NUM_UNITS = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 arm_i,
  input logic                 sample_valid_i,
  input logic                 cfg_wr_valid_i,
  input logic [NUM_UNITS-1:0] hit_o
);
  logic wrote_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrote_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      if (cfg_wr_valid_i) wrote_q <= 1'b1;
      if (arm_i) seen_q <= 1'b0;
      else if (sample_valid_i) seen_q <= 1'b1;
    end
  end

  p_unprog_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrote_q |=> hit_o == '0);
  p_idle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> hit_o == '0);
  p_arm_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> hit_o == '0);
  p_first_sample_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !seen_q) |=> hit_o == '0);
endmodule

bind edge_lut_trig edge_lut_trig_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .sample_valid_i(sample_valid_i),
  .cfg_wr_valid_i(cfg_wr_valid_i), .hit_o(hit_o)
);

// File: tb/sim_edge_lut_trig.sv
module sim_edge_lut_trig;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, arm = 1'b0, sval = 1'b0;
  logic [31:0] smp = '0;
  logic        csel_v = 1'b0, cwr_v = 1'b0;
  logic [7:0]  csel = '0;
  logic [31:0] cwr = '0;
  logic [1:0]  hit;

  edge_lut_trig u0 (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .sample_valid_i(sval), .sample_i(smp),
    .cfg_sel_valid_i(csel_v), .cfg_sel_i(csel), .cfg_wr_valid_i(cwr_v),
    .cfg_wr_data_i(cwr), .hit_o(hit)
  );

  typedef struct { logic [1:0] exp; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [15:0] m_lut [2][16];
  int          m_unit = -1, m_ptr = 0;
  logic [31:0] m_prev = '0;
  bit          m_pv = 0;

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(bit ok, string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model_hit(logic [31:0] pv, logic [31:0] cur);
    logic [1:0] r = '0;
    for (int u = 0; u < 2; u++)
      for (int p = 0; p < 16; p++) begin
        logic [3:0] ix = {pv[2*p+1], pv[2*p], cur[2*p+1], cur[2*p]};
        if (m_lut[u][p][ix]) r[u] = 1'b1;
      end
    return r;
  endfunction

  // R2 encodings
  function automatic logic [15:0] pat(bit hi, bit r, bit f, bit n);
    logic [15:0] rt = hi ? 16'h00CC : 16'h0A0A;
    logic [15:0] ft = hi ? 16'h3300 : 16'h5050;
    if (n) return ~(rt | ft);
    return (r ? rt : 16'h0) | (f ? ft : 16'h0);
  endfunction

  function automatic logic [15:0] pair_tbl(int p, logic [31:0] rs, logic [31:0] fl, logic [31:0] nt);
    return pat(1, rs[2*p+1], fl[2*p+1], nt[2*p+1]) | pat(0, rs[2*p], fl[2*p], nt[2*p]);
  endfunction

  task automatic send(logic [31:0] d, string tag);
    sval = 1'b1; smp = d;
    q.push_back('{m_pv ? model_hit(m_prev, d) : 2'b00, tag});
    m_prev = d; m_pv = 1;
    step(); sval = 1'b0; smp = ~d;  // junk while idle
  endtask

  task automatic arm_with(bit with_sample, logic [31:0] d);
    arm = 1'b1; m_pv = 0;
    if (with_sample) begin
      sval = 1'b1; smp = d;
      q.push_back('{2'b00, "R8 arm-cycle sample"});
    end
    step(); arm = 1'b0; sval = 1'b0;
  endtask

  task automatic sel(logic [7:0] code, bit with_wr, logic [31:0] d);
    csel_v = 1'b1; csel = code; cwr_v = with_wr; cwr = d;
    m_unit = (code == 8'h34) ? 0 : (code == 8'h35) ? 1 : -1;
    m_ptr = 0;
    step(); csel_v = 1'b0; cwr_v = 1'b0;
  endtask

  task automatic wr(logic [31:0] d);
    cwr_v = 1'b1; cwr = d;
    if (m_unit >= 0 && m_ptr < 8) begin
      m_lut[m_unit][15-2*m_ptr] = d[31:16];
      m_lut[m_unit][14-2*m_ptr] = d[15:0];
      m_ptr++;
    end
    step(); cwr_v = 1'b0;
  endtask

  task automatic load(logic [7:0] code, logic [31:0] rs, logic [31:0] fl, logic [31:0] nt);
    sel(code, 0, '0);
    for (int k = 0; k < 8; k++) wr({pair_tbl(15-2*k, rs, fl, nt), pair_tbl(14-2*k, rs, fl, nt)});
  endtask

  // monitor
  logic v_q = 1'b0;
  always @(posedge clk) v_q <= sval;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && !done) begin
      if (v_q) begin
        if (q.size() == 0) chk(0, "R6 unexpected result", hit, 2'b00);
        else begin
          e = q.pop_front();
          chk(hit === e.exp, e.tag, hit, e.exp);
        end
      end else chk(hit === 2'b00, "R6 idle cycle", hit, 2'b00);
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1; n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < 2; u++) for (int p = 0; p < 16; p++) m_lut[u][p] = '0;
    step(); step();
    rst_n = 1'b1;
    @(negedge clk); chk(hit === 2'b00, "R1 reset state", hit, 2'b00);
    step();
    // R1: unprogrammed never hits
    send(32'h0, "R1 quiet"); send(32'hFFFF_FFFF, "R1 quiet");
    send(32'h0, "R1 quiet"); send(32'h5555_AAAA, "R1 quiet");
    // R2/R8: rising on ch0, unit 0
    load(8'h34, 32'h1, 32'h0, 32'h0);
    arm_with(0, '0);
    send(32'h1, "R8 first sample after arm");
    send(32'h0, "R2 no rise"); send(32'h1, "R2 rise ch0");
    send(32'h1, "R2 steady"); send(32'h0, "R2 fall ignored"); send(32'h1, "R2 rise ch0 again");
    // R8: sample in arm cycle dropped
    arm_with(1, 32'h0);
    send(32'h1, "R8 first after arm-drop");
    send(32'h0, "R8 compare"); send(32'h1, "R8 rise after arm");
    // R4/R9: falling on ch31 unit 1 (first write, upper half)
    load(8'h35, 32'h0, 32'h8000_0000, 32'h0);
    send(32'h8000_0000, "R9 setup"); send(32'h0, "R4 fall ch31");
    send(32'h8000_0001, "R9 rise ch0 unit0 only"); send(32'h0000_0000, "R9 fall ch31 unit1");
    // R5: OR of several pairs in unit 0
    load(8'h34, 32'h0000_4001, 32'h0002_0000, 32'h0);
    send(32'h0002_0000, "R5 setup"); send(32'h0000_0000, "R5 fall ch17");
    send(32'h0000_4000, "R5 rise ch14"); send(32'h0002_4001, "R5 rise ch0 with ch17 rise");
    send(32'h0000_4001, "R5 fall ch17 again");
    // R7: idle cycles with changing data do not update previous
    send(32'h0, "R7 base");
    smp = 32'hFFFF_FFFF; step(); step(); step();
    send(32'h0, "R7 no rise across gap"); send(32'h1, "R7 rise after gap");
    // R2: constant on ch5 (high of pair 2) unit 0, any edge on ch6 unit 1
    load(8'h34, 32'h0, 32'h0, 32'h20);
    load(8'h35, 32'h40, 32'h40, 32'h0);
    send(32'h20, "R2 const setup"); send(32'h20, "R2 const ch5");
    send(32'h0, "R2 ch5 change"); send(32'h40, "R2 any edge rise ch6");
    send(32'h0, "R2 any edge fall ch6"); send(32'h0, "R2 const low ch5");
    // R3: unknown codes, writes ignored
    sel(8'h36, 0, '0);
    for (int k = 0; k < 8; k++) wr(32'hFFFF_FFFF);
    sel(8'h33, 0, '0);
    wr(32'hFFFF_FFFF);
    send(32'h20, "R3 unknown select"); send(32'h20, "R3 unknown select const");
    send(32'h0, "R3 unknown select change");
    // R3: write in select cycle dropped (pair 15 of unit 1)
    sel(8'h35, 1, 32'hFFFF_FFFF);
    send(32'h8000_0000, "R3 sel+wr setup"); send(32'h8000_0000, "R3 sel+wr dropped");
    // R4: partial reload keeps other pairs
    wr(32'hFFFF_0000);
    send(32'h8000_0000, "R4 partial pair15"); send(32'h0000_0040, "R4 other pairs kept");
    send(32'h0, "R4 other pairs kept fall");
    // R4: ninth write ignored
    sel(8'h34, 0, '0);
    for (int k = 0; k < 8; k++) wr(32'h0);
    wr(32'hFFFF_FFFF);
    send(32'h1, "R4 ninth write ignored"); send(32'h0, "R4 ninth write ignored");
    send(32'h20, "R4 ninth write ignored");
    step(); step(); step();
    if (q.size() != 0) chk(0, "R6 results missing", 2'b00, 2'b00);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule